// File: doc/BRIEF.md
# Halfword-Tracking Instruction Fetch Frontend

This block sits between a pipelined instruction memory bus and a decode stage. It fetches aligned 32-bit words, buffers them in a short prefetch queue, and presents a 32-bit current-instruction register to decode. The register's contents are counted in halfwords, so 16-bit and 32-bit instructions can be mixed freely. A 32-bit instruction may begin at any halfword and may straddle two fetched words. Decode reports how many halfwords it takes each cycle. An instruction is 32 bits wide when its two lowest bits are both one, and 16 bits wide otherwise.

Decode redirects fetch through a valid/ready jump port. A plain jump discards everything that has been fetched. Data still in flight on the bus for the old path is dropped when it returns. The next instruction is then presented from the jump target. A jump may also be flagged as hold-and-redirect. In that case the instruction now sitting in decode is kept, and only the fetches behind it are discarded and restarted at the target. The jump port is not ready in the first cycle after reset, and it stays not ready from a hold-and-redirect until decode consumes the held instruction.

On the bus, one ready signal stalls both phases. An address is accepted on a cycle where address-valid and ready are both high. Its data returns on a later cycle where ready is high, and the bus flags that cycle with data-valid. Back-pressure on the decode side comes from the consumed count alone: decode never takes more halfwords than are valid.

Top module: `fetch_frontend`

## Requirements
- R1: The valid-halfword count is 0, 1 or 2, and never 3. It is 0 after reset.
- R2: When the count is at least k+1, halfword k of the instruction register (bits 16k+15:16k) equals the memory halfword at PC+2k. PC starts at the reset vector and advances by 2 × consumed count. Decode consumes 2 halfwords when bits 1:0 are 2'b11, otherwise 1.
- R3: A jump is taken when jump-valid and jump-ready are both high, and bit 0 of the target is always 0. Without hold, the next halfwords presented come from the target; target bit 1 set means the upper halfword of that word comes first. Bus data for the old path never reaches the register.
- R4: A hold-and-redirect is requested only with the held instruction fully valid and nothing consumed in that cycle. It keeps that instruction's halfwords in place. If the held instruction is 16-bit, the upper halfword is next refilled from the target. Once the held instruction is consumed, presentation continues from the target.
- R5: Jump-ready is low in the first cycle after reset release. It is also low from an accepted hold-and-redirect until the cycle in which decode consumes a nonzero count.
- R6: Fetch addresses are word aligned. The first is the reset vector's word, each accepted address is followed by the next word, and after a jump fetch restarts at the target's word.
- R7: The prefetch queue holds QUEUE_WORDS words. No address is issued while queued words plus live in-flight transfers would exceed it, so with decode stalled after a jump to an aligned target, exactly QUEUE_WORDS+1 addresses are accepted and the count settles at 2.
- R8: A bus error on a returned word sets the error flag of every halfword taken from that word. Flag bit k belongs to halfword k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | output | 32 | Fetch word address |
| bus_addr_valid | output | 1 | Fetch address is being offered |
| bus_ready | input | 1 | Bus ready for both address and data phase |
| bus_rvalid | input | 1 | Data phase completes this cycle |
| bus_rdata | input | 32 | Returned word |
| bus_rerr | input | 1 | Returned word carries a bus error |
| jmp_target | input | 32 | Jump target address, bit 0 zero |
| jmp_valid | input | 1 | Jump request |
| jmp_ready | output | 1 | Jump request can be accepted |
| cir | output | 32 | Current instruction register, halfword 0 in bits 15:0 |
| cir_count | output | 2 | Number of valid halfwords |
| cir_take | input | 2 | Halfwords consumed by decode this cycle |
| cir_err | output | 2 | Per-halfword bus error flags |
| cir_hold | input | 1 | Accompanying jump keeps the held instruction |

## Verification
The bench aims jumps at odd halfword targets while transfers are in flight and the bus stalls at random. A design that let stale data through, or that ignored target bit 1, would show a halfword from the wrong address. Hold-and-redirect is exercised with both 16-bit and 32-bit held instructions. A design that kept the stale upper half after a 16-bit hold, or that split a held 32-bit instruction, would mismatch the model's upper halfword. A stalled-decode run counts the accepted addresses, which exposes a queue limit that is off by one. A run over an error word shows whether the flags follow the halfwords through the straddling 32-bit case.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef struct packed {
    logic        err;
    logic [31:0] data;
  } fe_word_t;

  // Halfwords occupied by the instruction whose low bits are given.
  function automatic logic [1:0] fe_ilen(input logic [1:0] lsb);
    return (lsb == 2'b11) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/fe_addr_gen.sv
module fe_addr_gen #(
  parameter logic [31:0] RESET_VECTOR = 32'h0000_0040,
  parameter int          QUEUE_WORDS  = 2,
  parameter int          FLIGHT_W     = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               redirect,
  input  logic [31:2]                        redirect_word,
  input  logic [$clog2(QUEUE_WORDS+1)-1:0]   q_count,
  input  logic                               bus_ready,
  input  logic                               bus_rvalid,
  output logic [31:0]                        bus_addr,
  output logic                               bus_addr_valid,
  output logic                               word_keep
);

  logic [31:2]         fetch_word;
  logic [FLIGHT_W-1:0] inflight;
  logic [FLIGHT_W-1:0] drop;
  logic [FLIGHT_W-1:0] live_flight;
  logic [FLIGHT_W-1:0] inflight_nxt;
  logic                addr_acc;

  assign live_flight    = inflight - drop;
  assign bus_addr_valid = (int'(q_count) + int'(live_flight)) < QUEUE_WORDS;
  assign bus_addr       = {fetch_word, 2'b00};
  assign addr_acc       = bus_addr_valid && bus_ready;
  assign inflight_nxt   = inflight + FLIGHT_W'(addr_acc) - FLIGHT_W'(bus_rvalid);
  // Transfers complete in order, so the dropped ones are always the oldest.
  assign word_keep      = bus_rvalid && (drop == '0) && !redirect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_word <= RESET_VECTOR[31:2];
      inflight   <= '0;
      drop       <= '0;
    end else begin
      inflight <= inflight_nxt;
      if (redirect) begin
        fetch_word <= redirect_word;
        drop       <= inflight_nxt;
      end else begin
        if (addr_acc) fetch_word <= fetch_word + 30'd1;
        if (bus_rvalid && (drop != '0)) drop <= drop - FLIGHT_W'(1);
      end
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_acc && !redirect) |=> (bus_addr == $past(bus_addr) + 32'd4)); // R6

  AST_DROP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    drop <= inflight); // R3

endmodule

// File: rtl/fe_word_queue.sv
module fe_word_queue
  import fe_pkg::*;
#(
  parameter int QUEUE_WORDS = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear,
  input  logic                             push,
  input  fe_word_t                         push_word,
  input  logic                             pop,
  output fe_word_t                         head,
  output logic [$clog2(QUEUE_WORDS+1)-1:0] count
);

  localparam int QCW = $clog2(QUEUE_WORDS + 1);
  localparam int PW  = (QUEUE_WORDS > 1) ? $clog2(QUEUE_WORDS) : 1;

  fe_word_t        slot_q [QUEUE_WORDS];
  logic [PW-1:0]   wr_ptr;
  logic [PW-1:0]   rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(QUEUE_WORDS - 1)) ? '0 : p + PW'(1);
  endfunction

  assign head = slot_q[rd_ptr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < QUEUE_WORDS; i++) begin
      if (push && !clear && (wr_ptr == PW'(i))) slot_q[i] <= push_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + QCW'(push) - QCW'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clear) |-> (int'(count) < QUEUE_WORDS)); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0)); // R2

endmodule

// File: rtl/fe_cir.sv
module fe_cir
  import fe_pkg::*;
#(
  parameter logic RESET_HALF = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  take,
  input  logic        redirect,
  input  logic        hold,
  input  logic        redirect_half,
  input  fe_word_t    head,
  input  logic        head_valid,
  output logic [31:0] cir,
  output logic [1:0]  cir_count,
  output logic [1:0]  cir_err,
  output logic        pop
);

  logic [1:0][15:0] hw_q, sh_h, nh;
  logic [1:0]       he_q, sh_e, ne;
  logic [1:0]       cnt_q, rem, space, avail, nfill, ncnt, end_ptr;
  logic             hptr_q;
  logic [15:0]      src0;

  always_comb begin
    rem  = cnt_q - take;
    sh_h = hw_q;
    sh_e = he_q;
    if (take == 2'd1) begin
      sh_h[0] = hw_q[1];
      sh_e[0] = he_q[1];
    end
    space = 2'd2 - rem;
    avail = !head_valid ? 2'd0 : (hptr_q ? 2'd1 : 2'd2);
    nfill = (space < avail) ? space : avail;
    src0  = hptr_q ? head.data[31:16] : head.data[15:0];
    nh    = sh_h;
    ne    = sh_e;
    if (nfill != 2'd0) begin
      if (rem == 2'd0) begin
        nh[0] = src0;
        ne[0] = head.err;
        if (nfill == 2'd2) begin
          nh[1] = head.data[31:16];
          ne[1] = head.err;
        end
      end else begin
        nh[1] = src0;
        ne[1] = head.err;
      end
    end
    ncnt    = rem + nfill;
    end_ptr = {1'b0, hptr_q} + nfill;
    pop     = !redirect && (nfill != 2'd0) && (end_ptr == 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q   <= '0;
      he_q   <= '0;
      cnt_q  <= '0;
      hptr_q <= RESET_HALF;
    end else if (redirect) begin
      cnt_q  <= hold ? fe_ilen(hw_q[0][1:0]) : 2'd0;
      hptr_q <= redirect_half;
    end else begin
      hw_q  <= nh;
      he_q  <= ne;
      cnt_q <= ncnt;
      if (pop)                  hptr_q <= 1'b0;
      else if (nfill != 2'd0)   hptr_q <= end_ptr[0];
    end
  end

  assign cir       = {hw_q[1], hw_q[0]};
  assign cir_count = cnt_q;
  assign cir_err   = he_q;

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cir_count != 2'd3); // R1

  AST_TAKE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    take <= cir_count); // R2

  AST_REDIRECT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !hold) |=> (cir_count == 2'd0)); // R3

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && hold) |=> ((cir_count == $past(fe_ilen(cir[1:0])))
                            && (cir[15:0] == $past(cir[15:0])))); // R4

endmodule

// File: rtl/fetch_frontend.sv
module fetch_frontend
  import fe_pkg::*;
#(
  parameter logic [31:0] RESET_VECTOR = 32'h0000_0040,
  parameter int          QUEUE_WORDS  = 2,
  parameter int          FLIGHT_W     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] bus_addr,
  output logic        bus_addr_valid,
  input  logic        bus_ready,
  input  logic        bus_rvalid,
  input  logic [31:0] bus_rdata,
  input  logic        bus_rerr,
  input  logic [31:0] jmp_target,
  input  logic        jmp_valid,
  output logic        jmp_ready,
  output logic [31:0] cir,
  output logic [1:0]  cir_count,
  input  logic [1:0]  cir_take,
  output logic [1:0]  cir_err,
  input  logic        cir_hold
);

  localparam int QCW = $clog2(QUEUE_WORDS + 1);

  logic           first_cyc;
  logic           locked;
  logic           redirect;
  logic           hold;
  logic           word_keep;
  logic           q_pop;
  logic [QCW-1:0] q_count;
  fe_word_t       q_head;
  fe_word_t       q_in;

  assign jmp_ready = !first_cyc && !locked;
  assign redirect  = jmp_valid && jmp_ready;
  assign hold      = redirect && cir_hold;
  assign q_in      = '{err: bus_rerr, data: bus_rdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_cyc <= 1'b1;
      locked    <= 1'b0;
    end else begin
      first_cyc <= 1'b0;
      if (hold)                    locked <= 1'b1;
      else if (cir_take != 2'd0)   locked <= 1'b0;
    end
  end

  fe_addr_gen #(
    .RESET_VECTOR (RESET_VECTOR),
    .QUEUE_WORDS  (QUEUE_WORDS),
    .FLIGHT_W     (FLIGHT_W)
  ) u_addr (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect       (redirect),
    .redirect_word  (jmp_target[31:2]),
    .q_count        (q_count),
    .bus_ready      (bus_ready),
    .bus_rvalid     (bus_rvalid),
    .bus_addr       (bus_addr),
    .bus_addr_valid (bus_addr_valid),
    .word_keep      (word_keep)
  );

  fe_word_queue #(
    .QUEUE_WORDS (QUEUE_WORDS)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (redirect),
    .push      (word_keep),
    .push_word (q_in),
    .pop       (q_pop),
    .head      (q_head),
    .count     (q_count)
  );

  fe_cir #(
    .RESET_HALF (RESET_VECTOR[1])
  ) u_cir (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (cir_take),
    .redirect      (redirect),
    .hold          (hold),
    .redirect_half (jmp_target[1]),
    .head          (q_head),
    .head_valid    (q_count != '0),
    .cir           (cir),
    .cir_count     (cir_count),
    .cir_err       (cir_err),
    .pop           (q_pop)
  );

  AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !jmp_target[0]); // R3

  AST_HOLD_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> ((cir_take == 2'd0) && (cir_count >= fe_ilen(cir[1:0])))); // R4

endmodule

// File: tb/tb_fetch_frontend.sv
`timescale 1ns/1ps
module tb_fetch_frontend;

  localparam logic [31:0] RV  = 32'h0000_0040;
  localparam real         CLK = 5.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr;
  logic        bus_addr_valid;
  logic        bus_ready = 1'b0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        bus_rerr;
  logic [31:0] jmp_target = '0;
  logic        jmp_valid = 1'b0;
  logic        jmp_ready;
  logic [31:0] cir;
  logic [1:0]  cir_count;
  logic [1:0]  cir_take = '0;
  logic [1:0]  cir_err;
  logic        cir_hold = 1'b0;

  always #(CLK / 2.0) clk = ~clk;

  fetch_frontend #(.RESET_VECTOR(RV)) dut (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_addr_valid(bus_addr_valid), .bus_ready(bus_ready),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_rerr(bus_rerr),
    .jmp_target(jmp_target), .jmp_valid(jmp_valid), .jmp_ready(jmp_ready),
    .cir(cir), .cir_count(cir_count), .cir_take(cir_take), .cir_err(cir_err),
    .cir_hold(cir_hold)
  );

  // Memory: halfword at byte address a holds a[16:1]; some words report an error.
  function automatic bit bad_word(input logic [31:0] a);
    return a[7:2] == 6'h15;
  endfunction

  logic        dp_pend;
  logic [31:0] dp_addr;
  assign bus_rvalid = bus_ready && dp_pend;
  assign bus_rdata  = bus_rvalid ? {dp_addr[16:2], 1'b1, dp_addr[16:2], 1'b0} : 32'h0;
  assign bus_rerr   = bus_rvalid && bad_word(dp_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_pend <= 1'b0;
      dp_addr <= '0;
    end else if (bus_ready) begin
      dp_pend <= bus_addr_valid;
      if (bus_addr_valid) dp_addr <= bus_addr;
    end
  end

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  // Reference model state
  logic [31:0] m_pc  = RV;
  logic [31:0] m_tgt = '0;
  bit          m_locked = 0;
  string       m_tag = "R2";
  logic [31:0] exp_fa = RV;
  int          n_acc = 0;
  int          err_seen = 0;
  int          holds16 = 0;
  int          holds32 = 0;

  // Stimulus policy
  bit          p_take = 1, p_jump = 0, p_hold = 0, p_rdy = 0, f_jump = 0;
  logic [31:0] f_target = '0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_cycle();
    logic [31:0] a1;
    logic [31:0] tg;
    logic [1:0]  tk;
    int          ilen;
    bit          can, jv, hd, rdy;
    // compare outputs with the model
    check(cir_count != 2'd3, "R1", 32'(cir_count), 32'd2);
    if (cir_count >= 2'd1) begin
      check(cir[15:0] == m_pc[16:1], m_locked ? "R4" : m_tag, 32'(cir[15:0]), 32'(m_pc[16:1]));
      check(cir_err[0] == bad_word(m_pc), "R8", 32'(cir_err[0]), 32'(bad_word(m_pc)));
      if (bad_word(m_pc)) err_seen++;
    end
    if (cir_count >= 2'd2) begin
      a1 = (m_locked && cir[1:0] != 2'b11) ? m_tgt : m_pc + 32'd2;
      check(cir[31:16] == a1[16:1], m_locked ? "R4" : m_tag, 32'(cir[31:16]), 32'(a1[16:1]));
      check(cir_err[1] == bad_word(a1), "R8", 32'(cir_err[1]), 32'(bad_word(a1)));
    end
    if (m_locked) check(!jmp_ready, "R5", 32'(jmp_ready), 32'd0);
    // choose inputs
    ilen = (cir[1:0] == 2'b11) ? 2 : 1;
    can  = int'(cir_count) >= ilen;
    tk   = (p_take && can && ($urandom % 3 != 0)) ? 2'(ilen) : 2'd0;
    jv   = f_jump || (p_jump && ($urandom % 10 == 0));
    tg   = f_jump ? f_target : ($urandom & 32'h0000_0ffe);
    hd   = !f_jump && p_hold && jv && jmp_ready && can && (tk == 2'd0) && ($urandom % 2 == 0);
    rdy  = p_rdy || ($urandom % 4 != 0);
    cir_take   = tk;
    jmp_valid  = jv;
    jmp_target = tg;
    cir_hold   = hd;
    bus_ready  = rdy;
    // fetch address sequence
    if (bus_addr_valid && rdy) begin
      check(bus_addr == exp_fa, "R6", bus_addr, exp_fa);
      exp_fa = exp_fa + 32'd4;
      n_acc++;
    end
    // advance model across the coming edge
    if (jv && jmp_ready) begin
      if (hd) begin
        m_locked = 1;
        m_tgt    = tg;
        if (ilen == 1) holds16++; else holds32++;
      end else begin
        m_pc  = tg;
        m_tag = "R3";
      end
      exp_fa = {tg[31:2], 2'b00};
    end else if (m_locked && tk != 2'd0) begin
      m_pc     = m_tgt;
      m_locked = 0;
      m_tag    = "R4";
    end else if (tk != 2'd0) begin
      m_pc  = m_pc + {29'd0, tk, 1'b0};
      m_tag = "R2";
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      do_cycle();
    end
  endtask

  task automatic forced_jump(input logic [31:0] t, input bit take_after);
    p_jump = 0; p_hold = 0; p_take = 1; p_rdy = 1;
    for (int i = 0; i < 100 && !jmp_ready; i++) begin
      @(negedge clk);
      do_cycle();
    end
    @(negedge clk);
    p_take = 0; f_jump = 1; f_target = t;
    do_cycle();
    f_jump = 0; n_acc = 0; p_take = take_after;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(cir_count == 2'd0, "R1", 32'(cir_count), 32'd0);
    check(!jmp_ready, "R5", 32'(jmp_ready), 32'd0);
    check(bus_addr_valid && bus_addr == RV, "R6", bus_addr, RV);
    do_cycle();

    // mixed traffic with jumps, holds and bus stalls
    p_take = 1; p_jump = 1; p_hold = 1; p_rdy = 0;
    run(1500);

    // R7: stalled decode after an aligned jump fetches one CIR word plus the queue
    forced_jump(32'h0000_0400, 0);
    run(20);
    check(n_acc == 3, "R7", 32'(n_acc), 32'd3);
    check(cir_count == 2'd2, "R7", 32'(cir_count), 32'd2);

    // R8: run through a word that reports an error, odd-halfword entry first
    forced_jump(32'h0000_0052, 1);
    p_rdy = 0;
    run(60);

    // R3: odd-halfword jump target while transfers are in flight
    forced_jump(32'h0000_0106, 1);
    p_rdy = 0;
    run(40);

    p_take = 1; p_jump = 1; p_hold = 1; p_rdy = 0;
    run(2500);

    check(holds16 > 0, "R4", 32'(holds16), 32'd1);
    check(holds32 > 0, "R4", 32'(holds32), 32'd1);
    check(err_seen > 0, "R8", 32'(err_seen), 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(CLK * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R2: actual no completion expected completion at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule